// File: doc/BRIEF.md
# Serial Slave Hold-Pause Gate

This block sits between the pins of a serial-memory slave and its shift logic. A host can pause a transfer part-way through a byte by pulling an active-low pause pin. While paused, the serial clock and data input are ignored and the data output driver is released. The partial byte survives the pause, so the transfer continues from the same bit once the pin is released.

All five asynchronous inputs are brought into the system clock domain through a two-flop synchroniser. A state machine then watches the synchronised chip select, serial clock and pause pin. A pause may start or end only while the serial clock is low. An edge of the pause pin that arrives while the clock is high is held pending until the clock next falls. The qualified rising and falling clock strobes drive a bit-counting shift model, which shifts MSB first. The model stands in for the command logic downstream and makes the frozen bit position visible at the ports.

If chip select is released during a pause, the serial logic is cleared. The block then stays locked out until the pause pin is high while the slave is deselected. Only after that does a new chip-select assertion open a transfer. A busy flag from the internal write engine passes through untouched by any pause.

States of `spi_hold_fsm`:
- IDLE: deselected. It goes to ACTIVE when chip select is low.
- ACTIVE: strobes pass. Chip select high goes to IDLE. Pause low with clock low goes to HOLD. Pause low with clock high goes to ENTER_PEND.
- ENTER_PEND: strobes still pass. Chip select high goes to IDLE. Pause high again goes back to ACTIVE. Clock low goes to HOLD.
- HOLD: paused. Chip select high goes to LOCKOUT. Pause high with clock low goes to ACTIVE. Pause high with clock high goes to EXIT_PEND.
- EXIT_PEND: still paused. Chip select high goes to LOCKOUT. Pause low again goes back to HOLD. Clock low goes to ACTIVE.
- LOCKOUT: serial logic cleared. It goes to IDLE only when chip select and the pause pin are both high.

Top module: `spi_hold_gate`

## Requirements
- R1: After reset, hold_active, dout_oe, sclk_rise, sclk_fall, byte_done, bit_count and shift_data are all 0.
- R2: While chip select is high, driving the pause pin low never raises hold_active.
- R3: With chip select low and the serial clock low, a falling pause pin raises hold_active on the third system clock edge after the pin changes.
- R4: A pause pin that falls while the serial clock is high leaves hold_active at 0 until the clock goes low. hold_active then rises on the third edge after that clock-low pin change.
- R5: A pause pin that rises while the serial clock is low clears hold_active on the third edge. If the clock is high at that moment, hold_active stays 1 until the clock goes low.
- R6: While hold_active is 1, dout_oe is 0 and no sclk_rise or sclk_fall strobe is issued, whatever the serial clock and data input do.
- R7: bit_count and shift_data keep their values through a pause. A byte split across a pause completes with the correct value.
- R8: busy_out equals busy_in delayed by two system clocks, whether or not a pause is in progress.
- R9: Chip select going high during a pause clears bit_count and shift_data to 0.
- R10: After R9, serial clocks are ignored (dout_oe 0, bit_count stays 0) until the pause pin is high while chip select is high. A later chip-select assertion then starts a normal transfer.
- R11: Each serial clock rising edge outside a pause gives one sclk_rise strobe and shifts din_bit in MSB first. The eighth bit pulses byte_done for one cycle and returns bit_count to 0.
- R12: Chip select going high in the middle of a byte clears bit_count and shift_data to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Chip select pin, active low |
| sclk_pin | input | 1 | Serial clock pin |
| mosi_pin | input | 1 | Serial data input pin |
| hold_n_pin | input | 1 | Pause pin, active low |
| busy_in | input | 1 | Write-in-progress flag from the internal engine |
| hold_active | output | 1 | Pause in effect |
| dout_oe | output | 1 | Enable for the serial data output driver |
| sclk_rise | output | 1 | Qualified serial clock rising strobe |
| sclk_fall | output | 1 | Qualified serial clock falling strobe |
| din_bit | output | 1 | Synchronised serial data input |
| busy_out | output | 1 | Synchronised busy flag |
| bit_count | output | CNT_W | Bit position within the current byte |
| shift_data | output | DATA_W | Shift register contents |
| byte_done | output | 1 | One-cycle pulse when a byte completes |

## Verification
Some properties are checked by assertions on every cycle:
- A pause begins or ends only on a cycle whose synchronised serial clock was low.
- A pause blocks the output enable and both strobes.
- The shift state does not move without a strobe.
- A deselect during a pause always leads to the lockout state, and that state is left only with both pins high.
- busy_out follows busy_in with a two-cycle lag.

Other behaviours need the bench's scenarios: the exact three-edge entry and exit latency, the deferral while the clock is high, a byte split across a pause reaching the right value, and a lockout that ignores clocks until the pin order is honoured.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_ACTIVE     = 3'd1,
        ST_ENTER_PEND = 3'd2,
        ST_HOLD       = 3'd3,
        ST_EXIT_PEND  = 3'd4,
        ST_LOCKOUT    = 3'd5
    } hold_state_e;

    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= RST_VAL;
            end
        end else begin
            chain_q[0] <= d_async;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
    import spi_hold_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_s,
    input  logic        sck_s,
    input  logic        hold_s,
    output hold_state_e state,
    output logic        hold_active,
    output logic        dout_oe,
    output logic        sclk_rise,
    output logic        sclk_fall,
    output logic        logic_clear
);

    hold_state_e state_q, state_d;
    logic        sck_d;
    logic        pass;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sck_d   <= 1'b0;
        end else begin
            state_q <= state_d;
            sck_d   <= sck_s;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_s) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (cs_s)         state_d = ST_IDLE;
                else if (!hold_s) state_d = sck_s ? ST_ENTER_PEND : ST_HOLD;
            end
            ST_ENTER_PEND: begin
                if (cs_s)        state_d = ST_IDLE;
                else if (hold_s) state_d = ST_ACTIVE;
                else if (!sck_s) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (cs_s)        state_d = ST_LOCKOUT;
                else if (hold_s) state_d = sck_s ? ST_EXIT_PEND : ST_ACTIVE;
            end
            ST_EXIT_PEND: begin
                if (cs_s)         state_d = ST_LOCKOUT;
                else if (!hold_s) state_d = ST_HOLD;
                else if (!sck_s)  state_d = ST_ACTIVE;
            end
            ST_LOCKOUT: begin
                if (cs_s && hold_s) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        pass        = 1'b0;
        hold_active = 1'b0;
        logic_clear = 1'b0;
        unique case (state_q)
            ST_IDLE:       logic_clear = 1'b1;
            ST_ACTIVE:     pass        = 1'b1;
            ST_ENTER_PEND: pass        = 1'b1;
            ST_HOLD:       hold_active = 1'b1;
            ST_EXIT_PEND:  hold_active = 1'b1;
            ST_LOCKOUT:    logic_clear = 1'b1;
            default:       logic_clear = 1'b1;
        endcase
        dout_oe   = pass;
        sclk_rise = pass &&  sck_s && !sck_d;
        sclk_fall = pass && !sck_s &&  sck_d;
    end

    assign state = state_q;

    // A pause can only begin on a cycle whose synchronised clock was low
    assert_entry_on_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_active) |-> !$past(sck_s));

    assert_deferred_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTER_PEND && sck_s && !cs_s && !hold_s) |=> !hold_active);

    // Leaving a pause towards ACTIVE only happens on a clock-low cycle
    assert_exit_on_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && $past(hold_active)) |-> !$past(sck_s));

    assert_no_hold_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !hold_active);

    assert_deselect_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && cs_s) |=> (state_q == ST_LOCKOUT));

    assert_lockout_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_LOCKOUT && state_q != ST_LOCKOUT) |-> ($past(cs_s) && $past(hold_s)));

endmodule

// File: rtl/spi_hold_shift.sv
module spi_hold_shift #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rise,
    input  logic              din,
    output logic [CNT_W-1:0]  bit_count,
    output logic [DATA_W-1:0] shift_data,
    output logic              byte_done
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_count  <= '0;
            shift_data <= '0;
            byte_done  <= 1'b0;
        end else if (clear) begin
            bit_count  <= '0;
            shift_data <= '0;
            byte_done  <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (rise) begin
                shift_data <= {shift_data[DATA_W-2:0], din};
                if (bit_count == LAST_BIT) begin
                    bit_count <= '0;
                    byte_done <= 1'b1;
                end else begin
                    bit_count <= bit_count + 1'b1;
                end
            end
        end
    end

    assert_frozen_without_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && !clear) |=> ($stable(bit_count) && $stable(shift_data)));

    assert_clear_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (bit_count == '0 && shift_data == '0));

    assert_done_wraps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> (bit_count == '0));

endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
    import spi_hold_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_pin,
    input  logic              sclk_pin,
    input  logic              mosi_pin,
    input  logic              hold_n_pin,
    input  logic              busy_in,
    output logic              hold_active,
    output logic              dout_oe,
    output logic              sclk_rise,
    output logic              sclk_fall,
    output logic              din_bit,
    output logic              busy_out,
    output logic [CNT_W-1:0]  bit_count,
    output logic [DATA_W-1:0] shift_data,
    output logic              byte_done
);

    localparam int         PIN_W    = 5;
    localparam logic [4:0] PIN_RST  = 5'b01001; // {busy, hold_n, mosi, sclk, cs_n}

    logic [PIN_W-1:0] pins_s;
    logic             cs_s, sck_s, mosi_s, hold_s, busy_s;
    hold_state_e      state;
    logic             logic_clear;

    spi_hold_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_RST)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({busy_in, hold_n_pin, mosi_pin, sclk_pin, cs_n_pin}),
        .q_sync (pins_s)
    );

    assign {busy_s, hold_s, mosi_s, sck_s, cs_s} = pins_s;

    spi_hold_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_s       (cs_s),
        .sck_s      (sck_s),
        .hold_s     (hold_s),
        .state      (state),
        .hold_active(hold_active),
        .dout_oe    (dout_oe),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .logic_clear(logic_clear)
    );

    spi_hold_shift #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (logic_clear),
        .rise      (sclk_rise),
        .din       (mosi_s),
        .bit_count (bit_count),
        .shift_data(shift_data),
        .byte_done (byte_done)
    );

    assign din_bit  = mosi_s;
    assign busy_out = busy_s;

    // Cycles since reset, saturating, so the busy lag check never looks before reset
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= 2'd0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    assert_hold_gates_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> (!dout_oe && !sclk_rise && !sclk_fall));

    assert_busy_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (busy_out == $past(busy_in, 2)));

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd0) |-> (!hold_active && !dout_oe && bit_count == '0));

endmodule

// File: tb/spi_hold_gate_tb_top.sv
module spi_hold_gate_tb_top;

    localparam int DW = 8;
    localparam int CW = 3;

    localparam int M_OFF = 0, M_RUN = 1, M_GO_P = 2, M_PAUSED = 3, M_LEAVE_P = 4, M_BLOCK = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n_pin = 1'b1, sclk_pin = 1'b0, mosi_pin = 1'b0, hold_n_pin = 1'b1, busy_in = 1'b0;
    logic hold_active, dout_oe, sclk_rise, sclk_fall, din_bit, busy_out, byte_done;
    logic [CW-1:0] bit_count;
    logic [DW-1:0] shift_data;

    int checks = 0;
    int failures = 0;
    int rise_cnt = 0;
    int done_cnt = 0;
    int paused_strobes = 0;
    bit finished = 0;

    always #2 clk = ~clk; // 250 MHz

    spi_hold_gate #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sclk_pin(sclk_pin),
        .mosi_pin(mosi_pin), .hold_n_pin(hold_n_pin), .busy_in(busy_in),
        .hold_active(hold_active), .dout_oe(dout_oe), .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall), .din_bit(din_bit), .busy_out(busy_out),
        .bit_count(bit_count), .shift_data(shift_data), .byte_done(byte_done)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    bit q_cs[$], q_ck[$], q_md[$], q_hd[$], q_bz[$];
    int mode = M_OFF;
    int m_cnt = 0;
    int m_data = 0;
    bit m_done = 0;

    task automatic model_reset();
        q_cs = '{1, 1, 1, 1}; q_ck = '{0, 0, 0, 0}; q_md = '{0, 0, 0, 0};
        q_hd = '{1, 1, 1, 1}; q_bz = '{0, 0, 0, 0};
        mode = M_OFF; m_cnt = 0; m_data = 0; m_done = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit cs, ck, ckp, hd, md, live, up;
            q_cs.push_front(cs_n_pin); void'(q_cs.pop_back());
            q_ck.push_front(sclk_pin); void'(q_ck.pop_back());
            q_md.push_front(mosi_pin); void'(q_md.pop_back());
            q_hd.push_front(hold_n_pin); void'(q_hd.pop_back());
            q_bz.push_front(busy_in); void'(q_bz.pop_back());
            cs = q_cs[2]; ck = q_ck[2]; ckp = q_ck[3]; hd = q_hd[2]; md = q_md[2];
            live = (mode == M_RUN || mode == M_GO_P);
            up = live && ck && !ckp;
            if (mode == M_OFF || mode == M_BLOCK) begin
                m_cnt = 0; m_data = 0; m_done = 0;
            end else begin
                m_done = 0;
                if (up) begin
                    m_data = ((m_data << 1) | md) & 8'hFF;
                    if (m_cnt == DW - 1) begin m_cnt = 0; m_done = 1; end
                    else m_cnt++;
                end
            end
            case (mode)
                M_OFF:     if (!cs) mode = M_RUN;
                M_RUN:     if (cs) mode = M_OFF; else if (!hd) mode = ck ? M_GO_P : M_PAUSED;
                M_GO_P:    if (cs) mode = M_OFF; else if (hd) mode = M_RUN; else if (!ck) mode = M_PAUSED;
                M_PAUSED:  if (cs) mode = M_BLOCK; else if (hd) mode = ck ? M_LEAVE_P : M_RUN;
                M_LEAVE_P: if (cs) mode = M_BLOCK; else if (!hd) mode = M_PAUSED; else if (!ck) mode = M_RUN;
                default:   if (cs && hd) mode = M_OFF;
            endcase
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit live, e_rise, e_fall;
            live = (mode == M_RUN || mode == M_GO_P);
            e_rise = live && q_ck[1] && !q_ck[2];
            e_fall = live && !q_ck[1] && q_ck[2];
            chk(hold_active == (mode == M_PAUSED || mode == M_LEAVE_P), "R3", "model hold_active", hold_active, (mode == M_PAUSED || mode == M_LEAVE_P));
            chk(dout_oe == live, "R6", "model dout_oe", dout_oe, live);
            chk(sclk_rise == e_rise, "R11", "model sclk_rise", sclk_rise, e_rise);
            chk(sclk_fall == e_fall, "R11", "model sclk_fall", sclk_fall, e_fall);
            chk(int'(bit_count) == m_cnt, "R7", "model bit_count", bit_count, m_cnt);
            chk(int'(shift_data) == m_data, "R7", "model shift_data", shift_data, m_data);
            chk(byte_done == m_done, "R11", "model byte_done", byte_done, m_done);
            chk(busy_out == q_bz[1], "R8", "model busy_out", busy_out, q_bz[1]);
            if (sclk_rise) rise_cnt++;
            if (byte_done) done_cnt++;
            if (hold_active && (sclk_rise || sclk_fall)) paused_strobes++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        mosi_pin = b;
        wait_n(4);
        sclk_pin = 1'b1;
        wait_n(4);
        sclk_pin = 1'b0;
    endtask

    task automatic send_bits(input int val, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) send_bit(val[i]);
        wait_n(4);
    endtask

    initial begin
        int r0, d0;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        // R1 reset state
        chk(!hold_active && !dout_oe && !sclk_rise && !sclk_fall && !byte_done, "R1", "idle flags", {hold_active, dout_oe, sclk_rise, sclk_fall, byte_done}, 0);
        chk(bit_count == 0 && shift_data == 0, "R1", "idle shift state", shift_data, 0);

        // R2 pause while deselected
        hold_n_pin = 1'b0; wait_n(6);
        chk(!hold_active, "R2", "hold_active while deselected", hold_active, 0);
        hold_n_pin = 1'b1; wait_n(4);

        // R11 plain byte
        cs_n_pin = 1'b0; wait_n(4);
        r0 = rise_cnt; d0 = done_cnt;
        send_bits(8'hA5, 8);
        chk(shift_data == 8'hA5, "R11", "byte A5", shift_data, 8'hA5);
        chk(rise_cnt - r0 == 8, "R11", "rise strobes per byte", rise_cnt - r0, 8);
        chk(done_cnt - d0 == 1, "R11", "byte_done pulses", done_cnt - d0, 1);

        // R3/R7 byte split across a pause taken with clock low
        send_bits(8'h3C >> 5, 3);
        hold_n_pin = 1'b0; wait_n(2);
        chk(!hold_active, "R3", "hold latency edge 2", hold_active, 0);
        wait_n(1);
        chk(hold_active, "R3", "hold latency edge 3", hold_active, 1);
        send_bit(1'b1); send_bit(1'b0); wait_n(4);
        chk(bit_count == 3, "R7", "count frozen in hold", bit_count, 3);
        chk(shift_data[2:0] == 3'b001, "R7", "bits frozen in hold", shift_data[2:0], 1);
        chk(!dout_oe && paused_strobes == 0, "R6", "oe and strobes in hold", {dout_oe, paused_strobes != 0}, 0);
        hold_n_pin = 1'b1; wait_n(2);
        chk(hold_active, "R5", "release latency edge 2", hold_active, 1);
        wait_n(1);
        chk(!hold_active, "R5", "release latency edge 3", hold_active, 0);
        d0 = done_cnt;
        send_bits(8'h3C, 5);
        chk(shift_data == 8'h3C, "R7", "split byte 3C", shift_data, 8'h3C);
        chk(done_cnt - d0 == 1, "R7", "split byte done", done_cnt - d0, 1);

        // R4 deferred entry with clock high, R5 deferred exit, R8 busy
        mosi_pin = 1'b1; wait_n(4);
        sclk_pin = 1'b1; wait_n(4);
        hold_n_pin = 1'b0; wait_n(6);
        chk(!hold_active, "R4", "deferred entry while clock high", hold_active, 0);
        sclk_pin = 1'b0; wait_n(3);
        chk(hold_active, "R4", "entry after clock low", hold_active, 1);
        sclk_pin = 1'b1; wait_n(4);
        busy_in = 1'b1;
        hold_n_pin = 1'b1; wait_n(6);
        chk(hold_active, "R5", "deferred exit while clock high", hold_active, 1);
        chk(busy_out, "R8", "busy during hold", busy_out, 1);
        sclk_pin = 1'b0; wait_n(3);
        chk(!hold_active, "R5", "exit after clock low", hold_active, 0);
        chk(bit_count == 1, "R7", "rise in hold ignored", bit_count, 1);
        send_bits(8'h01, 7);
        chk(shift_data == 8'h81, "R7", "byte 81 after deferred pause", shift_data, 8'h81);

        // R9 deselect during hold
        send_bits(2'b11, 2);
        hold_n_pin = 1'b0; wait_n(4);
        cs_n_pin = 1'b1; wait_n(4);
        chk(bit_count == 0 && shift_data == 0, "R9", "cleared by deselect in hold", shift_data, 0);
        chk(busy_out, "R8", "busy unaffected by deselect", busy_out, 1);

        // R10 lockout
        cs_n_pin = 1'b0; wait_n(4);
        send_bits(3'b101, 3);
        chk(bit_count == 0 && !dout_oe, "R10", "clocks ignored while locked", bit_count, 0);
        hold_n_pin = 1'b1; wait_n(4);
        send_bits(1, 1);
        chk(bit_count == 0 && !dout_oe, "R10", "wrong release order stays locked", bit_count, 0);
        cs_n_pin = 1'b1; wait_n(4);
        cs_n_pin = 1'b0; wait_n(4);
        send_bits(8'h5A, 8);
        chk(shift_data == 8'h5A, "R10", "byte after proper restart", shift_data, 8'h5A);

        // R12 deselect mid byte
        send_bits(3'b111, 3);
        cs_n_pin = 1'b1; wait_n(4);
        chk(bit_count == 0 && shift_data == 0, "R12", "cleared by mid-byte deselect", shift_data, 0);
        busy_in = 1'b0; wait_n(4);
        chk(!busy_out, "R8", "busy falls", busy_out, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R11 watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule